// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves 8-bit words over a clocked serial link, least significant bit first. It can run as clock master or as clock slave. As master it drives its own serial clock from the system clock. As slave it takes the serial clock from outside, brings it into the system clock domain and finds its edges. A host side writes transmit words with a strobe and reads received words with a strobe. Interrupt pulses mark the end of each word and each buffer move. Error pulses report a receive word that had nowhere to go and a transmit slot that was empty when the next bit was due.

A buffer-mode input selects one of two schemes. In single mode the shift registers are the only storage. In double mode the port adds a transmit holding register in front of the shifter and a receive staging register behind the visible receive word. This lets a master send words back to back with no gap in the clock. It also gives the host a full word time of slack on the receive side.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, sdo and sclk_out are 1, irq_tx, irq_rx, ovr_err and und_err are 0, and rx_data is 0.
- R2: With master_sel=1 and a word loaded, sclk_out toggles every HALF_CYC system clocks, starting with a falling edge. sdo presents bit 0 first and changes only on falling edges. sdi is sampled on rising edges into bit positions 0 to 7 in order. The received word appears on rx_data, with a one-cycle irq_rx pulse, one cycle after the eighth rising edge.
- R3: As master, if no further word is available at the end of a word, sclk_out stays high and stops toggling. und_err never pulses in master mode.
- R4: As slave, edge_sel=0 samples sdi on rising edges of sclk_in and changes sdo on falling edges. edge_sel=1 does the opposite. The first drive edge of a freshly loaded word leaves bit 0 on sdo.
- R5: With dbuf_en=0, a write loads the shifter only when it is empty, and a write while a word is loaded has no effect. irq_tx pulses once at the end of every word.
- R6: With dbuf_en=1, a write fills the holding register only when it is empty, and a write while it is full has no effect. A held word moves into an empty shifter, or into the shifter at the end of a word. Such a move pulses irq_tx, and so does the end of every word. A master continues into a moved word with no gap in sclk_out.
- R7: In either mode, a finished word goes to rx_data with an irq_rx pulse when rx_data is empty. rd_stb marks rx_data as read.
- R8: With dbuf_en=1, a word that finishes while rx_data is unread waits in a staging register and raises no irq_rx. The next rd_stb moves it to rx_data and pulses irq_rx one cycle later.
- R9: When a word finishes and no storage is free (rx_data unread in single mode, or rx_data and staging both full in double mode), ovr_err pulses, the word is dropped and rx_data is unchanged.
- R10: As slave, if no new word has been loaded by the first drive edge after a word's last sample edge, und_err pulses once. When a word was written in time, und_err does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_sel | input | 1 | 1: generate serial clock, 0: take it from sclk_in |
| edge_sel | input | 1 | Slave sampling edge, 0 rising, 1 falling |
| dbuf_en | input | 1 | 1: double buffering on both directions |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sdi | input | 1 | Serial data in |
| wr_stb | input | 1 | Transmit write strobe |
| wr_data | input | 8 | Transmit word |
| rd_stb | input | 1 | Receive read strobe |
| sdo | output | 1 | Serial data out, 1 when no word is loaded |
| sclk_out | output | 1 | Generated serial clock, idles high |
| rx_data | output | 8 | Visible received word |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_rx | output | 1 | Receive interrupt pulse |
| ovr_err | output | 1 | Receive overrun pulse |
| und_err | output | 1 | Transmit underrun pulse (slave) |

## Verification
The hardest state to reach is double-mode receive with both the visible word and the staging register full. The bench gets there by clocking three slave words in a row without a read. The third one must then raise an overrun and leave rx_data untouched, and the next two reads must bring out the staged word and then clear. Slave underrun needs one serial drive edge after a word with nothing written. The bench produces it by toggling sclk_in once past the eighth bit. Back-to-back master words are reached by writing a second word while the first is still shifting and one more that must be ignored. The bench then measures the spacing of the falling edges across the word boundary.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic {
        SMP_RISE = 1'b0,
        SMP_FALL = 1'b1
    } smp_edge_e;

    // one-cycle serial clock events in the system clock domain
    typedef struct packed {
        logic smp;   // sample sdi
        logic drv;   // advance sdo
    } sps_evt_t;

endpackage

// File: rtl/sps_clkgen.sv
module sps_clkgen
    import sps_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    output logic     sclk_o,
    output sps_evt_t evt_o
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        evt_o = '0;
        if (en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.sclk = ~st_q.sclk;
                evt_o.smp = ~st_q.sclk;
                evt_o.drv = st_q.sclk;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = st_q.sclk;

    AST_SCLK_PARKS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> sclk_o);  // R3

endmodule

// File: rtl/sps_sync_edge.sv
module sps_sync_edge
    import sps_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sclk_i,
    input  smp_edge_e edge_sel,
    output sps_evt_t  evt_o
);
    typedef struct packed {
        logic [STAGES:0] chain;  // [0] newest, [STAGES] previous settled value
        logic [STAGES:0] warm;   // suppresses edges until the chain holds real input
    } st_t;

    st_t  st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d.chain = {st_q.chain[STAGES-1:0], sclk_i};
        st_d.warm  = {st_q.warm[STAGES-1:0], 1'b1};
        rise = st_q.warm[STAGES] &  st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
        fall = st_q.warm[STAGES] & ~st_q.chain[STAGES-1] &  st_q.chain[STAGES];
        evt_o.smp = (edge_sel == SMP_FALL) ? fall : rise;
        evt_o.drv = (edge_sel == SMP_FALL) ? rise : fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sps_rxbuf.sv
module sps_rxbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dbuf,
    input  logic         word_vld,
    input  logic [W-1:0] word,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         irq,
    output logic         ovr
);
    typedef struct packed {
        logic [W-1:0] vis;
        logic         full;
        logic [W-1:0] stg;
        logic         stg_full;
        logic         irq;
        logic         ovr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.ovr = 1'b0;
        // host read first, so a staged word can take the freed slot
        if (rd && st_q.full) begin
            st_d.full = 1'b0;
            if (dbuf && st_q.stg_full) begin
                st_d.vis      = st_q.stg;
                st_d.full     = 1'b1;
                st_d.stg_full = 1'b0;
                st_d.irq      = 1'b1;
            end
        end
        if (word_vld) begin
            if (!st_d.full) begin
                st_d.vis  = word;
                st_d.full = 1'b1;
                st_d.irq  = 1'b1;
            end else if (dbuf && !st_d.stg_full) begin
                st_d.stg      = word;
                st_d.stg_full = 1'b1;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.vis;
    assign irq  = st_q.irq;
    assign ovr  = st_q.ovr;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !st_q.stg_full && !word_vld |=> !st_q.full);  // R7
    AST_STAGE_BEHIND_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        dbuf && st_q.stg_full |-> st_q.full);  // R8
    AST_OVERRUN_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> $stable(data));  // R9

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import sps_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int HALF_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              edge_sel,
    input  logic              dbuf_en,
    input  logic              sclk_in,
    input  logic              sdi,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic              sdo,
    output logic              sclk_out,
    output logic [WORD_W-1:0] rx_data,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              ovr_err,
    output logic              und_err
);
    localparam int W   = WORD_W;
    localparam int BCW = $clog2(W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(W - 1);

    typedef struct packed {
        logic [W-1:0]   tx_sh;
        logic           tx_vld;
        logic           fresh;     // bit 0 already on sdo, skip next drive edge
        logic [W-1:0]   hold;
        logic           hold_full;
        logic [BCW-1:0] bit_cnt;
        logic           active;    // master clock running
        logic           pend_und;  // slave: word ended, next drive edge decides underrun
        logic [W-1:0]   rx_sh;
        logic           irq_tx;
        logic           und;
    } st_t;

    st_t      st_d, st_q;
    sps_evt_t m_evt, s_evt, evt;
    logic     eow;
    logic [W-1:0] rx_word;

    sps_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (st_q.active),
        .sclk_o (sclk_out),
        .evt_o  (m_evt)
    );

    sps_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk_in),
        .edge_sel (smp_edge_e'(edge_sel)),
        .evt_o    (s_evt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.irq_tx = 1'b0;
        st_d.und    = 1'b0;
        eow         = 1'b0;
        evt         = master_sel ? m_evt : s_evt;
        rx_word     = {sdi, st_q.rx_sh[W-1:1]};

        // sample edge: shift in, count bits
        if (evt.smp) begin
            st_d.rx_sh = rx_word;
            if (st_q.bit_cnt == LAST_BIT) begin
                st_d.bit_cnt = '0;
                eow          = 1'b1;
            end else begin
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end
        end

        // drive edge: underrun decision, then advance sdo
        if (evt.drv) begin
            if (st_q.pend_und) begin
                st_d.pend_und = 1'b0;
                st_d.und      = ~st_q.tx_vld;
            end
            if (st_q.fresh) begin
                st_d.fresh = 1'b0;
            end else if (st_q.tx_vld) begin
                st_d.tx_sh = st_q.tx_sh >> 1;
            end
        end

        if (eow) begin
            st_d.tx_vld   = 1'b0;
            st_d.irq_tx   = 1'b1;
            st_d.pend_und = ~master_sel;
        end

        // holding register feeds an empty shifter
        if (dbuf_en && st_q.hold_full && !st_d.tx_vld) begin
            st_d.tx_sh     = st_q.hold;
            st_d.tx_vld    = 1'b1;
            st_d.fresh     = 1'b1;
            st_d.hold_full = 1'b0;
            st_d.irq_tx    = 1'b1;
        end

        if (wr_stb) begin
            if (dbuf_en) begin
                if (!st_q.hold_full) begin
                    st_d.hold      = wr_data;
                    st_d.hold_full = 1'b1;
                end
            end else if (!st_q.tx_vld) begin
                st_d.tx_sh  = wr_data;
                st_d.tx_vld = 1'b1;
                st_d.fresh  = 1'b1;
            end
        end

        if (master_sel) begin
            st_d.active = st_q.active ? !(eow && !st_d.tx_vld) : st_d.tx_vld;
        end else begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sps_rxbuf #(.W(W)) u_rxbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbuf     (dbuf_en),
        .word_vld (eow),
        .word     (rx_word),
        .rd       (rd_stb),
        .data     (rx_data),
        .irq      (irq_rx),
        .ovr      (ovr_err)
    );

    assign sdo     = st_q.tx_vld ? st_q.tx_sh[0] : 1'b1;
    assign irq_tx  = st_q.irq_tx;
    assign und_err = st_q.und;

    AST_MASTER_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        master_sel && $past(master_sel) |-> !und_err);  // R3
    AST_WORD_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        eow |=> irq_tx);  // R5
    AST_FULL_HOLD_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dbuf_en && wr_stb && st_q.hold_full |=> st_q.hold == $past(st_q.hold));  // R6

endmodule

// File: tb/sync_shift_port_tb_top.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;
    localparam int HALF = 8;
    localparam int HP   = 8;   // slave half period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_sel = 1'b0, edge_sel = 1'b0, dbuf_en = 1'b0;
    logic sclk_in = 1'b1, sdi = 1'b0;
    logic wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic sdo, sclk_out, irq_tx, irq_rx, ovr_err, und_err;
    logic [7:0] rx_data;

    always #2 clk = ~clk;

    sync_shift_port #(.WORD_W(8), .HALF_CYC(HALF), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .edge_sel(edge_sel),
        .dbuf_en(dbuf_en), .sclk_in(sclk_in), .sdi(sdi), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .sdo(sdo), .sclk_out(sclk_out),
        .rx_data(rx_data), .irq_tx(irq_tx), .irq_rx(irq_rx), .ovr_err(ovr_err),
        .und_err(und_err)
    );

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    int n_txirq = 0, n_ovr = 0, n_und = 0, n_tog = 0;
    logic sclk_prev = 1'b1;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    int fall_t[$];
    bit done = 1'b0;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: scoreboard for received words and event counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_rx) begin
                if (rx_q.size() == 0) check_eq("R7 unexpected irq_rx", rx_data, -1);
                else check_eq("R7/R8 received word", rx_data, rx_q.pop_front());
            end
            if (irq_tx) n_txirq++;
            if (ovr_err) n_ovr++;
            if (und_err) n_und++;
            if (sclk_out != sclk_prev) n_tog++;
        end
        sclk_prev = sclk_out;
    end

    task automatic do_reset(input logic m, input logic e, input logic d);
        @(negedge clk);
        rst_n = 1'b0; master_sel = m; edge_sel = e; dbuf_en = d;
        sclk_in = ~e; sdi = 1'b0;
        tx_q.delete(); rx_q.delete(); fall_t.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v, input bit expect_sent);
        wr_stb = 1'b1; wr_data = v;
        if (expect_sent) tx_q.push_back(v);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic master_word(input logic [7:0] rxv, input bit push_rx);
        logic [7:0] cap;
        logic prev;
        int w;
        bit seen;
        if (push_rx) rx_q.push_back(rxv);
        prev = sclk_out;
        for (int i = 0; i < 8; i++) begin
            w = 0; seen = 1'b0;
            while (!seen && w < 400) begin
                @(negedge clk);
                w++;
                if (prev && !sclk_out) seen = 1'b1;
                prev = sclk_out;
            end
            if (!seen) check_eq("R2 falling edge timeout", 0, 1);
            fall_t.push_back(cyc);
            cap[i] = sdo;
            sdi = rxv[i];
        end
        if (tx_q.size() == 0) check_eq("R2 master word unexpected", cap, -1);
        else check_eq("R2 master tx word", cap, tx_q.pop_front());
    endtask

    task automatic slave_word(input logic [7:0] rxv, input bit push_rx, input bit chk_tx);
        logic [7:0] cap;
        logic idle;
        idle = ~edge_sel;
        if (push_rx) rx_q.push_back(rxv);
        for (int i = 0; i < 8; i++) begin
            sclk_in = ~idle;        // drive edge
            sdi = rxv[i];
            repeat (HP) @(negedge clk);
            cap[i] = sdo;
            sclk_in = idle;         // sample edge
            repeat (HP) @(negedge clk);
        end
        if (chk_tx) begin
            if (tx_q.size() == 0) check_eq("R4 slave word unexpected", cap, -1);
            else check_eq("R4 slave tx word", cap, tx_q.pop_front());
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int t0, u0, o0;
        // ---------------- R1 reset state
        do_reset(1'b1, 1'b0, 1'b0);
        check_eq("R1 sdo", sdo, 1);
        check_eq("R1 sclk_out", sclk_out, 1);
        check_eq("R1 irqs", {irq_tx, irq_rx}, 0);
        check_eq("R1 errors", {ovr_err, und_err}, 0);
        check_eq("R1 rx_data", rx_data, 0);

        // ---------------- master, single buffer: R2 R3 R5
        t0 = n_txirq;
        wr(8'hA5, 1'b1);
        master_word(8'h3C, 1'b1);
        repeat (2*HALF + 4) @(negedge clk);
        check_eq("R5 irq_tx at word end", n_txirq - t0, 1);
        rd();
        u0 = n_tog;
        repeat (60) @(negedge clk);
        check_eq("R3 clock stopped", n_tog - u0, 0);
        check_eq("R3 clock parked high", sclk_out, 1);
        check_eq("R3 no master underrun", n_und, 0);
        wr(8'h11, 1'b1);
        wr(8'h22, 1'b0);            // shifter loaded: must be ignored
        master_word(8'hC7, 1'b1);
        repeat (2*HALF + 4) @(negedge clk);
        u0 = n_tog;
        repeat (60) @(negedge clk);
        check_eq("R5 ignored write sent nothing", n_tog - u0, 0);
        rd();

        // ---------------- master, double buffer: R6 R8
        do_reset(1'b1, 1'b0, 1'b1);
        t0 = n_txirq;
        wr(8'h81, 1'b1);
        repeat (2) @(negedge clk);
        wr(8'h7E, 1'b1);
        wr(8'hEE, 1'b0);            // holding register full: ignored
        master_word(8'h12, 1'b1);
        master_word(8'h34, 1'b1);
        check_eq("R6 no gap at word boundary", fall_t[8] - fall_t[7], 2*HALF);
        check_eq("R2 half period", fall_t[1] - fall_t[0], 2*HALF);
        repeat (2*HALF + 4) @(negedge clk);
        check_eq("R6 irq_tx count", n_txirq - t0, 3);
        check_eq("R8 staged word not visible", rx_data, 8'h12);
        u0 = n_tog;
        repeat (60) @(negedge clk);
        check_eq("R6 ignored write sent nothing", n_tog - u0, 0);
        rd();                       // staged word moves up
        check_eq("R8 staged word visible after read", rx_data, 8'h34);
        rd();

        // ---------------- slave, sample rising, single buffer: R4 R7 R9 R10
        do_reset(1'b0, 1'b0, 1'b0);
        u0 = n_und; o0 = n_ovr;
        wr(8'hC3, 1'b1);
        slave_word(8'h5A, 1'b1, 1'b1);
        rd();
        wr(8'h0F, 1'b1);
        slave_word(8'hF0, 1'b1, 1'b1);
        wr(8'h99, 1'b1);
        slave_word(8'h77, 1'b0, 1'b1);
        check_eq("R9 single overrun flagged", n_ovr - o0, 1);
        check_eq("R9 single rx_data kept", rx_data, 8'hF0);
        check_eq("R10 no underrun when refilled", n_und - u0, 0);
        rd();
        sclk_in = 1'b0;             // one more drive edge, nothing written
        repeat (HP) @(negedge clk);
        check_eq("R10 underrun flagged", n_und - u0, 1);
        check_eq("R10 sdo idles high", sdo, 1);

        // ---------------- slave, sample falling, double buffer: R4 R8 R9
        do_reset(1'b0, 1'b1, 1'b1);
        o0 = n_ovr;
        wr(8'h3C, 1'b1);
        repeat (3) @(negedge clk);
        wr(8'hA7, 1'b1);
        slave_word(8'h66, 1'b1, 1'b1);
        slave_word(8'h99, 1'b1, 1'b1);
        check_eq("R8 second word staged", rx_data, 8'h66);
        slave_word(8'h44, 1'b0, 1'b0);
        check_eq("R9 double overrun flagged", n_ovr - o0, 1);
        check_eq("R9 double rx_data kept", rx_data, 8'h66);
        rd();
        check_eq("R8 staged word after read", rx_data, 8'h99);
        rd();

        check_eq("R7 all received words seen", rx_q.size(), 0);
        check_eq("R2 all sent words seen", tx_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule